// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single timer channel with its own counter. The counter runs up, down or center-aligned against a period value. A compare value is held in a shadow register and compared with the count. A three-bit mode code turns the compare result into a raw output level. The level can be held, set, cleared or toggled on a match. It can also be forced low or high, or follow either of two PWM shapes. A polarity stage and an output enable then produce the channel pin. Each match also raises a one-cycle flag.

A start pulse launches the counter. A one-pulse option stops the counter at the first period boundary. A fast option moves the set, clear or toggle action from the match itself to the start of the period in which the match would fall. All configuration arrives on plain input ports. The compare value takes effect at period boundaries, so PWM duty changes never split a period.

Top module: `tocc_channel`

## Requirements
- R1: Counting mode code 0 counts 0 up to `period` and wraps to 0. Code 1 counts from `period` down to 0 and reloads `period`. Code 2 counts 0 up to `period`, then down to 0, and repeats. A start pulse on an idle counter loads `period` in code 1 and 0 otherwise, and the count advances from the next cycle.
- R2: `dir_down` is 1 in mode code 1 and 0 in code 0. In code 2 it is 1 from the cycle after the count reaches `period` until the count reaches 1 again after passing through 0.
- R3: While the counter runs, `match_flag` is high in the cycle after each cycle in which the count equals the active compare value. This holds in every output mode, including the forced ones.
- R4: With output codes 001, 010 and 011, the raw output goes high, goes low or inverts in the cycle after a match. Code 000 leaves the raw output unchanged.
- R5: Code 100 drives the raw output low and code 101 drives it high one cycle later, whatever the count.
- R6: Code 110 (PWM A) makes the raw output high in the cycle after a count below the active compare value while counting up, or a count not above it while counting down. Code 111 (PWM B) is the inverse. A compare value above `period` makes PWM A constantly high.
- R7: The active compare value loads from `cmp_value` while the counter is stopped and at each period boundary. The period boundary is the wrap at `period` in code 0, the wrap at 0 in code 1, and the count of 0 while counting down in code 2. A match in the boundary cycle is judged against the old value.
- R8: With `one_pulse` high, the counter stops at its first period boundary and leaves the count at its restart value. `running` falls in the cycle after the boundary.
- R9: With `fast_en` high, codes 001 to 011 act only at a period boundary, and only when `cmp_value` is at most `period`. A match alone does not change the raw output.
- R10: `ch_out` equals the raw output XOR `pol_inv` when `out_en` is high, and is 0 when `out_en` is low.
- R11: While `rst` is high at a clock edge, the count, direction, running state, raw output and match flag all clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req | input | 1 | Start pulse for an idle counter |
| cnt_mode | input | 2 | Counting mode: 0 up, 1 down, 2 center |
| period | input | CNT_W | Counter top value |
| cmp_value | input | CNT_W | Compare value, shadowed |
| oc_mode | input | 3 | Output mode code |
| one_pulse | input | 1 | Stop the counter at the first boundary |
| fast_en | input | 1 | Move match actions to the period start |
| pol_inv | input | 1 | Invert the output polarity |
| out_en | input | 1 | Channel output enable |
| count | output | CNT_W | Current count |
| dir_down | output | 1 | Count direction, 1 = down |
| running | output | 1 | Counter is running |
| raw_out | output | 1 | Mode stage output before polarity |
| ch_out | output | 1 | Channel pin level |
| match_flag | output | 1 | Compare match pulse |

## Verification
Two events can land in the same cycle: a compare match and a period boundary that reloads the shadow compare register. One test sets the compare value equal to the period in toggle mode, so every match falls on the boundary. Another rewrites the compare value in the middle of a period and counts the high cycles of PWM A over two periods. The number of output high cycles and flag pulses is compared with hand-derived totals, which differ if the reload happens early or the match uses the new value.

// File: rtl/tocc_pkg.sv
package tocc_pkg;

    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_CENTER = 2'd2,
        CNT_RSVD   = 2'd3
    } cnt_dir_mode_e;

    typedef enum logic [2:0] {
        OC_FROZEN   = 3'b000,
        OC_SET      = 3'b001,
        OC_CLEAR    = 3'b010,
        OC_TOGGLE   = 3'b011,
        OC_FORCE_LO = 3'b100,
        OC_FORCE_HI = 3'b101,
        OC_PWM_A    = 3'b110,
        OC_PWM_B    = 3'b111
    } oc_mode_e;

    typedef struct packed {
        logic running;
        logic dir_down;
        logic boundary;
    } cnt_state_t;

    function automatic logic is_match_mode(oc_mode_e m);
        return (m == OC_SET) || (m == OC_CLEAR) || (m == OC_TOGGLE);
    endfunction

    function automatic logic match_action(oc_mode_e m, logic cur);
        case (m)
            OC_SET:    return 1'b1;
            OC_CLEAR:  return 1'b0;
            OC_TOGGLE: return ~cur;
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/tocc_counter.sv
module tocc_counter
    import tocc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] period,
    input  logic             run_req,
    input  logic             one_pulse,
    output logic [CNT_W-1:0] count,
    output cnt_state_t       st
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_dir_mode_e    cm;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_q, dir_d, run_q;
    logic             at_top, at_zero, bnd;

    assign cm      = cnt_dir_mode_e'(cnt_mode);
    assign at_top  = (cnt_q >= period);
    assign at_zero = (cnt_q == ZERO);

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        bnd   = 1'b0;
        case (cm)
            CNT_DOWN: begin
                bnd   = at_zero;
                cnt_d = at_zero ? period : cnt_q - ONE;
                dir_d = 1'b0;
            end
            CNT_CENTER: begin
                if (!dir_q) begin
                    if (at_top) begin
                        cnt_d = (period == ZERO) ? ZERO : period - ONE;
                        dir_d = (period != ZERO);
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end else begin
                    bnd = at_zero;
                    if (at_zero) begin
                        cnt_d = (period == ZERO) ? ZERO : ONE;
                        dir_d = 1'b0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            default: begin
                bnd   = at_top;
                cnt_d = at_top ? ZERO : cnt_q + ONE;
                dir_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
            dir_q <= 1'b0;
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
            if (bnd && one_pulse) run_q <= 1'b0;
        end else if (run_req) begin
            run_q <= 1'b1;
            cnt_q <= (cm == CNT_DOWN) ? period : ZERO;
            dir_q <= 1'b0;
        end
    end

    assign count       = cnt_q;
    assign st.running  = run_q;
    assign st.dir_down = (cm == CNT_DOWN) ? 1'b1 : ((cm == CNT_CENTER) ? dir_q : 1'b0);
    assign st.boundary = run_q && bnd;

    // R1: a running count within the period stays within it
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (rst)
        (run_q && (cnt_q <= period)) |=> (cnt_q <= $past(period)));

    // R8: one-pulse stops the counter right after the boundary
    a_r8_one_shot_stop: assert property (@(posedge clk) disable iff (rst)
        (run_q && bnd && one_pulse) |=> !run_q);

endmodule

// File: rtl/tocc_shadow.sv
module tocc_shadow
    import tocc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_state_t       st,
    input  logic [CNT_W-1:0] cmp_in,
    output logic [CNT_W-1:0] cmp_act
);
    always_ff @(posedge clk) begin
        if (rst)                          cmp_act <= '0;
        else if (!st.running || st.boundary) cmp_act <= cmp_in;
    end

    // R7: the active compare value holds between boundaries while running
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (st.running && !st.boundary) |=> $stable(cmp_act));

endmodule

// File: rtl/tocc_mode.sv
module tocc_mode
    import tocc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       oc_mode,
    input  logic             fast_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic [CNT_W-1:0] period,
    input  cnt_state_t       st,
    output logic             raw_q,
    output logic             match_q
);
    oc_mode_e md;
    logic     hit, fast_fire, pwm_a, raw_d;

    assign md        = oc_mode_e'(oc_mode);
    assign hit       = st.running && (count == cmp_act);
    assign fast_fire = fast_en && st.boundary && (cmp_in <= period);
    assign pwm_a     = st.dir_down ? (count <= cmp_act) : (count < cmp_act);

    always_comb begin
        raw_d = raw_q;
        case (md)
            OC_FORCE_LO: raw_d = 1'b0;
            OC_FORCE_HI: raw_d = 1'b1;
            OC_PWM_A:    raw_d = pwm_a;
            OC_PWM_B:    raw_d = ~pwm_a;
            OC_SET, OC_CLEAR, OC_TOGGLE: begin
                if (fast_en) raw_d = fast_fire ? match_action(md, raw_q) : raw_q;
                else         raw_d = hit ? match_action(md, raw_q) : raw_q;
            end
            default:     raw_d = raw_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            raw_q   <= raw_d;
            match_q <= hit;
        end
    end

    // R4: toggle inverts on a match when not in fast mode
    a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (md == OC_TOGGLE && !fast_en && hit) |=> (raw_q != $past(raw_q)));

    // R4: frozen code keeps the level
    a_r4_frozen_holds: assert property (@(posedge clk) disable iff (rst)
        (md == OC_FROZEN) |=> $stable(raw_q));

    // R5: forced high wins over any count
    a_r5_forced_high: assert property (@(posedge clk) disable iff (rst)
        (md == OC_FORCE_HI) |=> raw_q);

    // R9: in fast mode a match away from a boundary changes nothing
    a_r9_fast_quiet: assert property (@(posedge clk) disable iff (rst)
        (fast_en && is_match_mode(md) && !st.boundary) |=> $stable(raw_q));

endmodule

// File: rtl/tocc_channel.sv
module tocc_channel
    import tocc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_req,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic [2:0]       oc_mode,
    input  logic             one_pulse,
    input  logic             fast_en,
    input  logic             pol_inv,
    input  logic             out_en,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             running,
    output logic             raw_out,
    output logic             ch_out,
    output logic             match_flag
);
    cnt_state_t       st;
    logic [CNT_W-1:0] cnt_w, cmp_act;
    logic             raw_w, match_w;

    tocc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .cnt_mode(cnt_mode), .period(period),
        .run_req(run_req), .one_pulse(one_pulse), .count(cnt_w), .st(st)
    );

    tocc_shadow #(.CNT_W(CNT_W)) u_shd (
        .clk(clk), .rst(rst), .st(st), .cmp_in(cmp_value), .cmp_act(cmp_act)
    );

    tocc_mode #(.CNT_W(CNT_W)) u_mode (
        .clk(clk), .rst(rst), .oc_mode(oc_mode), .fast_en(fast_en),
        .count(cnt_w), .cmp_act(cmp_act), .cmp_in(cmp_value), .period(period),
        .st(st), .raw_q(raw_w), .match_q(match_w)
    );

    assign count      = cnt_w;
    assign dir_down   = st.dir_down;
    assign running    = st.running;
    assign raw_out    = raw_w;
    assign match_flag = match_w;
    assign ch_out     = out_en & (raw_w ^ pol_inv);

    // R3: a running count equal to the active compare gives a flag next cycle
    a_r3_flag_on_match: assert property (@(posedge clk) disable iff (rst)
        (st.running && (cnt_w == cmp_act)) |=> match_flag);

endmodule

// File: tb/tocc_channel_test.sv
`timescale 1ns/1ps
module tocc_channel_test;
    localparam int W = 16;
    localparam int N = 20;

    typedef struct packed {
        logic [1:0] cfg;
        logic [2:0] mode;
        logic [7:0] per;
        logic [7:0] cmp;
        logic       pol;
        logic       oen;
        logic       fast;
        logic [7:0] hi;
        logic [7:0] fl;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'b110, 8'd9, 8'd4,  1'b0, 1'b1, 1'b0, 8'd8,  8'd2}, // R6 PWM A up
        '{2'd0, 3'b111, 8'd9, 8'd4,  1'b0, 1'b1, 1'b0, 8'd12, 8'd2}, // R6 PWM B
        '{2'd0, 3'b110, 8'd9, 8'd4,  1'b1, 1'b1, 1'b0, 8'd12, 8'd2}, // R10 polarity
        '{2'd0, 3'b110, 8'd9, 8'd12, 1'b0, 1'b1, 1'b0, 8'd20, 8'd0}, // R6 cmp above period
        '{2'd0, 3'b110, 8'd9, 8'd0,  1'b0, 1'b1, 1'b0, 8'd0,  8'd2}, // R6 cmp zero
        '{2'd1, 3'b110, 8'd9, 8'd4,  1'b0, 1'b1, 1'b0, 8'd10, 8'd2}, // R1 down
        '{2'd2, 3'b110, 8'd5, 8'd2,  1'b0, 1'b1, 1'b0, 8'd8,  8'd4}, // R1 center
        '{2'd0, 3'b011, 8'd9, 8'd3,  1'b0, 1'b1, 1'b0, 8'd10, 8'd2}, // R4 toggle at 3
        '{2'd0, 3'b001, 8'd9, 8'd3,  1'b0, 1'b1, 1'b0, 8'd17, 8'd2}, // R4 set
        '{2'd0, 3'b010, 8'd9, 8'd3,  1'b1, 1'b1, 1'b0, 8'd20, 8'd2}, // R4 clear
        '{2'd0, 3'b101, 8'd9, 8'd3,  1'b0, 1'b1, 1'b0, 8'd20, 8'd2}, // R5 forced high
        '{2'd0, 3'b100, 8'd9, 8'd3,  1'b1, 1'b1, 1'b0, 8'd20, 8'd2}, // R5 forced low
        '{2'd0, 3'b000, 8'd9, 8'd3,  1'b0, 1'b1, 1'b0, 8'd0,  8'd2}, // R4 frozen
        '{2'd0, 3'b011, 8'd9, 8'd3,  1'b0, 1'b0, 1'b0, 8'd0,  8'd2}, // R10 disabled
        '{2'd0, 3'b011, 8'd9, 8'd3,  1'b0, 1'b1, 1'b1, 8'd10, 8'd2}, // R9 fast toggle
        '{2'd0, 3'b001, 8'd9, 8'd12, 1'b0, 1'b1, 1'b1, 8'd0,  8'd0}, // R9 fast, cmp above
        '{2'd0, 3'b011, 8'd9, 8'd9,  1'b0, 1'b1, 1'b0, 8'd10, 8'd2}  // R7 match on boundary
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, run_req = 1'b0, one_pulse = 1'b0, fast_en = 1'b0;
    logic pol_inv = 1'b0, out_en = 1'b1;
    logic [1:0] cnt_mode = 2'd0;
    logic [2:0] oc_mode = 3'b000;
    logic [W-1:0] period = '0, cmp_value = '0;
    logic [W-1:0] count;
    logic dir_down, running, raw_out, ch_out, match_flag;

    int n_cmp = 0, n_bad = 0;

    tocc_channel #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .run_req(run_req), .cnt_mode(cnt_mode),
        .period(period), .cmp_value(cmp_value), .oc_mode(oc_mode),
        .one_pulse(one_pulse), .fast_en(fast_en), .pol_inv(pol_inv),
        .out_en(out_en), .count(count), .dir_down(dir_down),
        .running(running), .raw_out(raw_out), .ch_out(ch_out),
        .match_flag(match_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        cnt_mode  = v.cfg;
        oc_mode   = v.mode;
        period    = {8'd0, v.per};
        cmp_value = {8'd0, v.cmp};
        pol_inv   = v.pol;
        out_en    = v.oen;
        fast_en   = v.fast;
        rst       = 1'b1;
        run_req   = 1'b0;
        repeat (2) @(negedge clk);
        rst     = 1'b0;
        run_req = 1'b1;
        @(negedge clk);
        run_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int hi, fl;
        vec_t v;

        // R11: reset clears everything, even with forced high selected
        oc_mode = 3'b101;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 count", int'(count), 0);
        check("R11 running", int'(running), 0);
        check("R11 dir_down", int'(dir_down), 0);
        check("R11 ch_out", int'(ch_out), 0);
        check("R11 match_flag", int'(match_flag), 0);

        // vector walk: high cycles and flag pulses over N cycles
        for (int i = 0; i < NV; i++) begin
            launch(VECS[i]);
            hi = 0;
            fl = 0;
            for (int j = 1; j <= N; j++) begin
                @(negedge clk);
                hi += int'(ch_out);
                fl += int'(match_flag);
            end
            check($sformatf("vec%0d high (R4/R5/R6/R9/R10)", i), hi, int'(VECS[i].hi));
            check($sformatf("vec%0d flags (R3)", i), fl, int'(VECS[i].fl));
        end

        // R8: one-pulse PWM B gives a single pulse, then the counter stops
        one_pulse = 1'b1;
        v = '{2'd0, 3'b111, 8'd9, 8'd4, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0};
        launch(v);
        hi = 0;
        for (int j = 1; j <= 30; j++) begin
            @(negedge clk);
            hi += int'(ch_out);
            if (j == 9)  check("R8 running before boundary", int'(running), 1);
            if (j == 10) check("R8 stopped after boundary", int'(running), 0);
        end
        check("R8 single pulse width", hi, 6);
        check("R8 rest count", int'(count), 0);
        one_pulse = 1'b0;

        // R7 and R1: compare rewritten mid-period applies after the wrap
        v = '{2'd0, 3'b110, 8'd9, 8'd4, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0};
        launch(v);
        hi = 0;
        for (int j = 1; j <= N; j++) begin
            @(negedge clk);
            hi += int'(ch_out);
            if (j == 3) cmp_value = 16'd7;
            if (j == 9)  check("R1 up count at top", int'(count), 9);
            if (j == 10) check("R1 up count wraps", int'(count), 0);
        end
        check("R7 shadowed duty change", hi, 11);

        // R2: center-aligned direction reporting
        v = '{2'd2, 3'b110, 8'd5, 8'd2, 1'b0, 1'b1, 1'b0, 8'd0, 8'd0};
        launch(v);
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (j == 3) begin
                check("R2 center rising dir", int'(dir_down), 0);
                check("R1 center rising count", int'(count), 3);
            end
            if (j == 7) begin
                check("R2 center falling dir", int'(dir_down), 1);
                check("R1 center falling count", int'(count), 3);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule